// File: doc/BRIEF.md
# Parallel Bounding-Box Span Rasterizer

This block fills a primitive into a frame buffer whose memory word is 128 bits wide. A command gives a shape (an axis-aligned rectangle or a triangle), a pixel depth of 8, 16 or 32 bits, an enclosing box, three edge equations for the triangle case, a fill colour, and the frame-buffer base and row stride in words. The box's horizontal extent is rounded outward to whole memory words. The block then visits every word of that widened box, one word per clock, and decides for all pixel lanes of the word at once whether each pixel is covered. A vertical line one pixel wide is a rectangle whose left and right bounds are equal.

For each word with at least one covered lane it emits the word address, the colour replicated across the word and a byte write mask. Memory is never read, because only whole-byte pixels exist, so a masked write is enough. Words with no covered lane are dropped in the scan and cost one clock each. The output uses a valid/ready handshake. A one-cycle done pulse closes each command.

Top module: `span_raster`

## Requirements
- R1: After reset, out_valid and done are low and cmd_ready is high.
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both high. cmd_ready stays low while the box is being scanned.
- R3: The depth code gives L lanes per word: 0 gives 16 lanes of 8 bits, 1 gives 8 lanes of 16 bits, 2 gives 4 lanes of 32 bits. The word columns run from floor(x0/L) to floor(x1/L). Rows run from y0 to y1, in left-to-right then top-to-bottom order. Each word's address is base + y*stride + column.
- R4: For a rectangle (shape code 0), the pixel in lane i of column c has x = c*L + i. It is covered when x0 <= x <= x1.
- R5: For a triangle (shape code 1), a pixel is covered when it lies within the box and every edge value A*x + B*y + C is non-negative (signed). Edge k uses bits [16k+15:16k] of the A and B inputs and bits [32k+31:32k] of the C input.
- R6: Lane i occupies bytes i*P to i*P+P-1 of the word, where P is 1, 2 or 4 bytes per pixel. Each of those mask bits equals that lane's coverage.
- R7: out_data repeats the low 8, 16 or 32 bits of the colour in every pixel slot, with the lowest byte of the colour in the lowest byte of the slot.
- R8: A word whose mask would be all zero produces no output.
- R9: While out_ready is held high, one word of the box is processed every clock, so a box row of covered words comes out on consecutive cycles.
- R10: While out_valid is high and out_ready is low, out_addr, out_data and out_mask hold their values.
- R11: done is high for exactly one cycle, the cycle after the last word of the box leaves the scan. cmd_ready is high again in that cycle.
- R12: A one-pixel-wide vertical line gives exactly one enabled lane in each emitted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_shape | input | 1 | 0 rectangle, 1 triangle |
| cmd_depth | input | 2 | 0: 8 bpp, 1: 16 bpp, 2: 32 bpp |
| cmd_x0 | input | COORD_W | Box left pixel |
| cmd_y0 | input | COORD_W | Box top row |
| cmd_x1 | input | COORD_W | Box right pixel |
| cmd_y1 | input | COORD_W | Box bottom row |
| cmd_edge_a | input | 3*COEF_W | Signed x coefficients of the three edges |
| cmd_edge_b | input | 3*COEF_W | Signed y coefficients of the three edges |
| cmd_edge_c | input | 3*ACC_W | Signed constants of the three edges |
| cmd_color | input | 32 | Fill colour |
| cmd_base | input | ADDR_W | Word address of row 0, column 0 |
| cmd_stride | input | ADDR_W | Words per row |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_addr | output | ADDR_W | Word address |
| out_data | output | WORD_BITS | Replicated fill data |
| out_mask | output | WORD_BITS/8 | Byte write mask |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
Rectangles are drawn at each depth. Their left and right edges fall mid-word, exactly on word boundaries, or on the same pixel, so that the lane-to-byte spread, the column rounding and the thin vertical line can each be told apart. A right-angled triangle whose slanted edge leaves the right word column empty for most rows separates the edge test from the box test and shows that empty words are dropped. The same rectangle is drawn once with the consumer always ready and once with it stalling in a pattern. Comparing the two word streams and the run of back-to-back words separates full throughput from correct behaviour under backpressure.

// File: rtl/span_raster_pkg.sv
package span_raster_pkg;

  typedef enum logic [1:0] {
    PIX8  = 2'd0,
    PIX16 = 2'd1,
    PIX32 = 2'd2
  } pix_depth_e;

  typedef enum logic {
    SHAPE_RECT = 1'b0,
    SHAPE_TRI  = 1'b1
  } shape_e;

  // log2 of bytes per pixel; unused code behaves as 32 bpp
  function automatic logic [2:0] bytes_log2(input logic [1:0] depth);
    case (depth)
      PIX8:    return 3'd0;
      PIX16:   return 3'd1;
      default: return 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/span_walker.sv
module span_walker #(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [COORD_W-1:0] col_lo,
  input  logic [COORD_W-1:0] col_hi,
  input  logic [COORD_W-1:0] row_lo,
  input  logic [COORD_W-1:0] row_hi,
  input  logic               step,
  output logic               busy,
  output logic [COORD_W-1:0] col,
  output logic [COORD_W-1:0] row,
  output logic               last
);

  logic [COORD_W-1:0] col_first, col_end, row_end;
  logic               row_done;

  assign row_done = (col == col_end);
  assign last     = busy && row_done && (row == row_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      col       <= '0;
      row       <= '0;
      col_first <= '0;
      col_end   <= '0;
      row_end   <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      col       <= col_lo;
      row       <= row_lo;
      col_first <= col_lo;
      col_end   <= col_hi;
      row_end   <= row_hi;
    end else if (busy && step) begin
      if (last) begin
        busy <= 1'b0;
      end else if (row_done) begin
        col <= col_first;
        row <= row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lane_cover.sv
module lane_cover
  import span_raster_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int COEF_W  = 16,
  parameter int ACC_W   = 32,
  parameter int LANES   = 16
) (
  input  logic                 shape,
  input  logic [1:0]           depth,
  input  logic [COORD_W-1:0]   col,
  input  logic [COORD_W-1:0]   row,
  input  logic [COORD_W-1:0]   x_lo,
  input  logic [COORD_W-1:0]   x_hi,
  input  logic [3*COEF_W-1:0]  edge_a,
  input  logic [3*COEF_W-1:0]  edge_b,
  input  logic [3*ACC_W-1:0]   edge_c,
  output logic [LANES-1:0]     lane_on
);

  localparam int LANE_LOG = $clog2(LANES);

  function automatic logic signed [ACC_W-1:0] edge_value(
    input logic signed [COEF_W-1:0] a,
    input logic signed [COEF_W-1:0] b,
    input logic signed [ACC_W-1:0]  c,
    input logic [COORD_W:0]         x,
    input logic [COORD_W-1:0]       y
  );
    logic signed [ACC_W-1:0] ax, by;
    ax = $signed({{(ACC_W-COEF_W){a[COEF_W-1]}}, a}) *
         $signed({{(ACC_W-COORD_W-1){1'b0}}, x});
    by = $signed({{(ACC_W-COEF_W){b[COEF_W-1]}}, b}) *
         $signed({{(ACC_W-COORD_W){1'b0}}, y});
    return ax + by + c;
  endfunction

  logic [2:0] lane_shift;
  assign lane_shift = 3'(LANE_LOG) - bytes_log2(depth);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [COORD_W:0]  px;
    logic              lane_used, in_span;
    logic [2:0]        edge_ok;

    assign px        = ({1'b0, col} << lane_shift) + (COORD_W+1)'(g);
    assign lane_used = ((g >> lane_shift) == 0);
    assign in_span   = (px >= {1'b0, x_lo}) && (px <= {1'b0, x_hi});

    for (genvar e = 0; e < 3; e++) begin : g_edge
      assign edge_ok[e] = !edge_value(edge_a[e*COEF_W +: COEF_W],
                                      edge_b[e*COEF_W +: COEF_W],
                                      edge_c[e*ACC_W +: ACC_W],
                                      px, row)[ACC_W-1];
    end

    assign lane_on[g] = lane_used && in_span &&
                        ((shape == SHAPE_RECT) || (&edge_ok));
  end

endmodule

// File: rtl/mask_expand.sv
module mask_expand
  import span_raster_pkg::*;
#(
  parameter int BYTES = 16
) (
  input  logic [BYTES-1:0]   lane_on,
  input  logic [1:0]         depth,
  input  logic [31:0]        color,
  output logic [BYTES-1:0]   byte_mask,
  output logic [8*BYTES-1:0] fill
);

  for (genvar j = 0; j < BYTES; j++) begin : g_byte
    always_comb begin
      case (depth)
        PIX8: begin
          byte_mask[j]     = lane_on[j];
          fill[8*j +: 8]   = color[7:0];
        end
        PIX16: begin
          byte_mask[j]     = lane_on[j/2];
          fill[8*j +: 8]   = color[8*(j%2) +: 8];
        end
        default: begin
          byte_mask[j]     = lane_on[j/4];
          fill[8*j +: 8]   = color[8*(j%4) +: 8];
        end
      endcase
    end
  end

endmodule

// File: rtl/span_raster.sv
module span_raster
  import span_raster_pkg::*;
#(
  parameter int COORD_W   = 12,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 32,
  parameter int ADDR_W    = 24,
  parameter int WORD_BITS = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic                   cmd_shape,
  input  logic [1:0]             cmd_depth,
  input  logic [COORD_W-1:0]     cmd_x0,
  input  logic [COORD_W-1:0]     cmd_y0,
  input  logic [COORD_W-1:0]     cmd_x1,
  input  logic [COORD_W-1:0]     cmd_y1,
  input  logic [3*COEF_W-1:0]    cmd_edge_a,
  input  logic [3*COEF_W-1:0]    cmd_edge_b,
  input  logic [3*ACC_W-1:0]     cmd_edge_c,
  input  logic [31:0]            cmd_color,
  input  logic [ADDR_W-1:0]      cmd_base,
  input  logic [ADDR_W-1:0]      cmd_stride,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [ADDR_W-1:0]      out_addr,
  output logic [WORD_BITS-1:0]   out_data,
  output logic [WORD_BITS/8-1:0] out_mask,
  output logic                   done
);

  localparam int BYTES    = WORD_BITS / 8;
  localparam int LANE_LOG = $clog2(BYTES);

  // latched command
  logic                 shape_r;
  logic [1:0]           depth_r;
  logic [COORD_W-1:0]   x0_r, x1_r;
  logic [3*COEF_W-1:0]  ea_r, eb_r;
  logic [3*ACC_W-1:0]   ec_r;
  logic [31:0]          color_r;
  logic [ADDR_W-1:0]    base_r, stride_r;

  // named internal events
  logic                 cmd_take;
  logic                 scan_busy, scan_step, scan_last, word_empty;
  logic [COORD_W-1:0]   scan_col, scan_row;
  logic [2*COORD_W-1:0] scan_pos;
  logic [1:0]           cfg_depth;
  logic                 out_free;

  logic [2:0]           cmd_shift;
  logic [COORD_W-1:0]   col_lo, col_hi;
  logic [BYTES-1:0]     lane_on, word_mask;
  logic [WORD_BITS-1:0] word_fill;
  logic [ADDR_W-1:0]    word_addr;

  assign cmd_ready = !scan_busy;
  assign cmd_take  = cmd_valid && cmd_ready;
  assign cmd_shift = 3'(LANE_LOG) - bytes_log2(cmd_depth);
  assign col_lo    = cmd_x0 >> cmd_shift;
  assign col_hi    = cmd_x1 >> cmd_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shape_r  <= SHAPE_RECT;
      depth_r  <= PIX8;
      x0_r     <= '0;
      x1_r     <= '0;
      ea_r     <= '0;
      eb_r     <= '0;
      ec_r     <= '0;
      color_r  <= '0;
      base_r   <= '0;
      stride_r <= '0;
    end else if (cmd_take) begin
      shape_r  <= cmd_shape;
      depth_r  <= cmd_depth;
      x0_r     <= cmd_x0;
      x1_r     <= cmd_x1;
      ea_r     <= cmd_edge_a;
      eb_r     <= cmd_edge_b;
      ec_r     <= cmd_edge_c;
      color_r  <= cmd_color;
      base_r   <= cmd_base;
      stride_r <= cmd_stride;
    end
  end

  span_walker #(.COORD_W(COORD_W)) i_walker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (cmd_take),
    .col_lo (col_lo),
    .col_hi (col_hi),
    .row_lo (cmd_y0),
    .row_hi (cmd_y1),
    .step   (scan_step),
    .busy   (scan_busy),
    .col    (scan_col),
    .row    (scan_row),
    .last   (scan_last)
  );

  lane_cover #(
    .COORD_W(COORD_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .LANES(BYTES)
  ) i_cover (
    .shape   (shape_r),
    .depth   (depth_r),
    .col     (scan_col),
    .row     (scan_row),
    .x_lo    (x0_r),
    .x_hi    (x1_r),
    .edge_a  (ea_r),
    .edge_b  (eb_r),
    .edge_c  (ec_r),
    .lane_on (lane_on)
  );

  mask_expand #(.BYTES(BYTES)) i_expand (
    .lane_on   (lane_on),
    .depth     (depth_r),
    .color     (color_r),
    .byte_mask (word_mask),
    .fill      (word_fill)
  );

  assign word_empty = (word_mask == '0);
  assign out_free   = !out_valid || out_ready;
  assign scan_step  = scan_busy && (word_empty || out_free);
  assign scan_pos   = {scan_row, scan_col};
  assign cfg_depth  = depth_r;
  assign word_addr  = base_r + ADDR_W'(scan_row) * stride_r + ADDR_W'(scan_col);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
      out_mask  <= '0;
      done      <= 1'b0;
    end else begin
      done <= scan_step && scan_last;
      if (scan_step && !word_empty) begin
        out_valid <= 1'b1;
        out_addr  <= word_addr;
        out_data  <= word_fill;
        out_mask  <= word_mask;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/span_raster_chk.sv
module span_raster_chk #(
  parameter int COORD_W   = 12,
  parameter int ADDR_W    = 24,
  parameter int WORD_BITS = 128
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [ADDR_W-1:0]      out_addr,
  input logic [WORD_BITS-1:0]   out_data,
  input logic [WORD_BITS/8-1:0] out_mask,
  input logic                   done,
  input logic                   scan_busy,
  input logic                   scan_step,
  input logic                   scan_last,
  input logic [2*COORD_W-1:0]   scan_pos,
  input logic [1:0]             cfg_depth
);

  localparam int BYTES = WORD_BITS / 8;

  logic [BYTES-1:0] odd_bytes, even_bytes, nib_low;
  always_comb begin
    for (int i = 0; i < BYTES; i++) begin
      even_bytes[i] = (i % 2 == 0) ? out_mask[i] : 1'b0;
      odd_bytes[i]  = (i % 2 == 1) ? out_mask[i] : 1'b0;
      nib_low[i]    = (i % 4 == 0) ? out_mask[i] : 1'b0;
    end
  end

  // R2
  cmd_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> scan_busy && !cmd_ready);

  // R6
  pair_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_depth == 2'd1 |-> (even_bytes << 1) == odd_bytes);

  // R6
  quad_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_depth == 2'd2 |-> (nib_low | (nib_low << 1) | (nib_low << 2) | (nib_low << 3)) == out_mask);

  // R7
  byte_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_depth == 2'd0 |-> out_data == {BYTES{out_data[7:0]}});

  // R8
  no_empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mask != '0);

  // R9
  scan_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy && out_ready |=> !scan_busy || scan_pos != $past(scan_pos));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data) && $stable(out_mask));

  // R11
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(scan_step && scan_last) && !scan_busy && cmd_ready);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind span_raster span_raster_chk #(
  .COORD_W(COORD_W), .ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS)
) i_span_raster_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_data  (out_data),
  .out_mask  (out_mask),
  .done      (done),
  .scan_busy (scan_busy),
  .scan_step (scan_step),
  .scan_last (scan_last),
  .scan_pos  (scan_pos),
  .cfg_depth (cfg_depth)
);

// File: tb/test_span_raster.sv
module test_span_raster;

  localparam int CW = 12;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_shape = 1'b0;
  logic [1:0]    cmd_depth = 2'd0;
  logic [CW-1:0] cmd_x0 = '0, cmd_y0 = '0, cmd_x1 = '0, cmd_y1 = '0;
  logic [47:0]   cmd_edge_a = '0, cmd_edge_b = '0;
  logic [95:0]   cmd_edge_c = '0;
  logic [31:0]   cmd_color = '0;
  logic [AW-1:0] cmd_base = '0, cmd_stride = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [AW-1:0] out_addr;
  logic [127:0]  out_data;
  logic [15:0]   out_mask;
  logic          done;

  always #5 clk = ~clk;

  span_raster i_span_raster (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_shape(cmd_shape), .cmd_depth(cmd_depth),
    .cmd_x0(cmd_x0), .cmd_y0(cmd_y0), .cmd_x1(cmd_x1), .cmd_y1(cmd_y1),
    .cmd_edge_a(cmd_edge_a), .cmd_edge_b(cmd_edge_b), .cmd_edge_c(cmd_edge_c),
    .cmd_color(cmd_color), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_data(out_data), .out_mask(out_mask), .done(done)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected and collected streams
  logic [AW-1:0]  exp_addr [64];
  logic [15:0]    exp_mask [64];
  logic [127:0]   exp_data [64];
  int             exp_n;
  logic [AW-1:0]  got_addr [64];
  logic [15:0]    got_mask [64];
  logic [127:0]   got_data [64];
  int             got_n, done_cnt, max_run;

  // reference: byte-first view of coverage
  task automatic build_expected();
    int bpp, lanes;
    exp_n = 0;
    bpp   = 1 << cmd_depth;
    lanes = 16 / bpp;
    for (int y = int'(cmd_y0); y <= int'(cmd_y1); y++) begin
      for (int c = int'(cmd_x0) / lanes; c <= int'(cmd_x1) / lanes; c++) begin
        logic [15:0]  m;
        logic [127:0] d;
        m = '0;
        for (int j = 0; j < 16; j++) begin
          int  x;
          bit  hit;
          x   = c * lanes + j / bpp;
          hit = (x >= int'(cmd_x0)) && (x <= int'(cmd_x1));
          if (cmd_shape) begin
            for (int e = 0; e < 3; e++) begin
              int a, b, k;
              a = int'($signed(cmd_edge_a[16*e +: 16]));
              b = int'($signed(cmd_edge_b[16*e +: 16]));
              k = int'($signed(cmd_edge_c[32*e +: 32]));
              if (a * x + b * y + k < 0) hit = 0;
            end
          end
          m[j]        = hit;
          d[8*j +: 8] = cmd_color[8*(j % bpp) +: 8];
        end
        if (m != 0 && exp_n < 64) begin
          exp_addr[exp_n] = cmd_base + AW'(y) * cmd_stride + AW'(c);
          exp_mask[exp_n] = m;
          exp_data[exp_n] = d;
          exp_n++;
        end
      end
    end
  endtask

  // rmode 0: always ready; 1: stalls one cycle in three
  task automatic run_cmd(input int rmode);
    int run_len;
    got_n = 0; done_cnt = 0; max_run = 0; run_len = 0;
    out_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R2", "cmd_ready while scanning", 128'(cmd_ready), 128'(0));
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (done) done_cnt++;
      if (out_valid && out_ready) begin
        if (got_n < 64) begin
          got_addr[got_n] = out_addr;
          got_mask[got_n] = out_mask;
          got_data[got_n] = out_data;
        end
        got_n++;
        run_len++;
        if (run_len > max_run) max_run = run_len;
      end else begin
        run_len = 0;
      end
      if (done_cnt > 0 && !out_valid) break;
      out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
      @(negedge clk);
    end
    out_ready = 1'b1;
    chk(done_cnt == 1, "R11", "done pulses", 128'(done_cnt), 128'(1));
    chk(cmd_ready == 1'b1, "R11", "cmd_ready after done", 128'(cmd_ready), 128'(1));
  endtask

  task automatic compare_stream(input string req);
    chk(got_n == exp_n, req, "word count", 128'(got_n), 128'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_addr[i] == exp_addr[i], "R3", "word address", 128'(got_addr[i]), 128'(exp_addr[i]));
      chk(got_mask[i] == exp_mask[i], req, "byte mask", 128'(got_mask[i]), 128'(exp_mask[i]));
      chk(got_data[i] == exp_data[i], "R7", "fill data", got_data[i], exp_data[i]);
    end
  endtask

  function automatic int mask_bits();
    int s = 0;
    for (int i = 0; i < got_n && i < 64; i++) s += $countones(got_mask[i]);
    return s;
  endfunction

  // rectangle vectors: depth, x0, y0, x1, y1, words expected, mask bits expected
  localparam logic [65:0] VECS [0:3] = '{
    {2'd0, 12'd3,  12'd2, 12'd20, 12'd3, 8'd4, 8'd36},
    {2'd1, 12'd5,  12'd0, 12'd5,  12'd3, 8'd4, 8'd8},
    {2'd2, 12'd2,  12'd1, 12'd9,  12'd1, 8'd3, 8'd32},
    {2'd0, 12'd16, 12'd5, 12'd47, 12'd5, 8'd2, 8'd32}
  };

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "out_valid in reset", 128'(out_valid), 128'(0));
    chk(cmd_ready == 1'b1, "R1", "cmd_ready in reset", 128'(cmd_ready), 128'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 128'(out_valid), 128'(0));
    chk(done == 1'b0, "R1", "done after reset", 128'(done), 128'(0));
    chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", 128'(cmd_ready), 128'(1));

    cmd_base   = 24'd1000;
    cmd_stride = 24'd40;
    cmd_color  = 32'hA1B2C3D4;
    cmd_shape  = 1'b0;

    // table of rectangles (R3, R4, R6, R12)
    for (int v = 0; v < 4; v++) begin
      {cmd_depth, cmd_x0, cmd_y0, cmd_x1, cmd_y1} = VECS[v][65:16];
      build_expected();
      run_cmd(0);
      compare_stream("R4");
      chk(got_n == int'(VECS[v][15:8]), "R3", "table word count", 128'(got_n), 128'(VECS[v][15:8]));
      chk(mask_bits() == int'(VECS[v][7:0]), "R6", "table mask bits", 128'(mask_bits()), 128'(VECS[v][7:0]));
      if (v == 1) begin
        // R12: vertical line at 16 bpp, lane 5 -> bytes 10,11
        for (int i = 0; i < got_n && i < 64; i++)
          chk(got_mask[i] == 16'h0C00, "R12", "single lane mask", 128'(got_mask[i]), 128'h0C00);
      end
    end

    // R9: four full words on one row at 8 bpp, back to back
    cmd_depth = 2'd0; cmd_x0 = 12'd0; cmd_x1 = 12'd63; cmd_y0 = 12'd7; cmd_y1 = 12'd7;
    build_expected();
    run_cmd(0);
    compare_stream("R4");
    chk(max_run == 4, "R9", "back-to-back words", 128'(max_run), 128'(4));

    // R10: same box under stalls must give the same stream
    run_cmd(1);
    compare_stream("R10");

    // R10: 32 bpp box spanning two rows with stalls
    cmd_depth = 2'd2; cmd_x0 = 12'd1; cmd_x1 = 12'd14; cmd_y0 = 12'd2; cmd_y1 = 12'd3;
    build_expected();
    run_cmd(1);
    compare_stream("R10");

    // R5, R8: triangle x>=2, y>=1, x+y<=20 at 8 bpp
    cmd_shape  = 1'b1;
    cmd_depth  = 2'd0;
    cmd_x0 = 12'd2; cmd_x1 = 12'd19; cmd_y0 = 12'd1; cmd_y1 = 12'd18;
    cmd_edge_a = {-16'sd1, 16'sd0,  16'sd1};
    cmd_edge_b = {-16'sd1, 16'sd1,  16'sd0};
    cmd_edge_c = {32'sd20, -32'sd1, -32'sd2};
    cmd_base   = 24'd100;
    cmd_stride = 24'd4;
    cmd_color  = 32'h0000005A;
    build_expected();
    run_cmd(0);
    compare_stream("R5");
    chk(got_n == 22, "R8", "empty words dropped", 128'(got_n), 128'(22));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule